// File: doc/BRIEF.md
# Fixed-Point Sine-Polynomial Control Law

This block turns a two-variable plant state into one scalar actuation value inside a real-time control loop. The two state samples, `inA1` and `inA2`, are signed fixed-point numbers with 16 fractional bits. The block applies a fixed law: a sine of the first state, expanded as an odd polynomial up to the fifth power, plus the first state, minus the second state, all scaled by a constant gain. The arithmetic uses only integer multiplies, adds and shifts. No floating-point logic is involved.

A new operand pair may be offered on every clock cycle with `inValid`. Each pair yields exactly one result on `outCtrl`, marked by a single-cycle `outValid`, after a fixed pipeline delay. Between results the output register keeps the last value, so the value can be read at any time.

Top module: `poly_ctrl_law`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its outputs: after that edge `outValid` is 0 and `outCtrl` is 0.
- R2: Every input and output word is a signed 32-bit value with 16 fractional bits, so 1.0 is 0x00010000, the step is about 0.0000153 and the span is about ±32768. The result equals G·(2·x − C6·x³ + C120·x⁵ − y), where x = `inA1` and y = `inA2`. The constants are encoded in the same format: G = 475935 (about 7.26219), C6 = 10923 (one sixth) and C120 = 546 (one hundred-twentieth).
- R3: Each fixed-point product is formed at full width and then shifted right by 16 bits, arithmetically, which rounds toward minus infinity. The powers x², x³ = x²·x and x⁵ = x³·x², and the two scaled terms C6·x³ and C120·x⁵, are each clamped to the signed 32-bit range before later use. The bracketed sum is formed without loss.
- R4: When the scaled result exceeds the signed 32-bit range, `outCtrl` is 0x7FFFFFFF for positive overflow and 0x80000000 for negative overflow. It never wraps.
- R5: A pair sampled with `inValid` high at a rising edge produces its result with `outValid` high exactly 6 rising edges later. `outValid` is never high except as such a response.
- R6: Pairs may be offered on consecutive cycles without gaps. Each pair gives its own result, in the order the pairs arrived.
- R7: When `inValid` is low, the values on `inA1` and `inA2` are ignored. `outCtrl` holds the last result and does not change while `outValid` is low.
- R8: An all-zero operand pair produces a result of exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks the operand pair as valid in this cycle |
| inA1 | input | 32 | First state, signed Q16.16 |
| inA2 | input | 32 | Second state, signed Q16.16 |
| outValid | output | 1 | Single-cycle strobe marking a new result |
| outCtrl | output | 32 | Control result, signed Q16.16, saturated |

## Verification
The bench builds the block with its default parameters: a 32-bit word with 16 fractional bits and the three stated coefficient encodings. These values put both clamping points within reach of modest operands. A first state of 100.0 already clamps its cube and fifth power, and the output then saturates negative. A second state at the most negative code drives the output to positive saturation. The same parameters keep exact small cases, such as ±1.0 and zero, in a range where the floor rounding of every product can be predicted bit for bit.

// File: rtl/poly_ctrl_pkg.sv
package poly_ctrl_pkg;

  // Number of register stages between an accepted operand pair and its result.
  localparam int PIPE_DEPTH = 6;

  // Load strobes issued by the control unit to the datapath, one per stage.
  typedef struct packed {
    logic ldSquare;
    logic ldCube;
    logic ldFifth;
    logic ldTerms;
    logic ldSum;
    logic ldOut;
  } polyStrobe_t;

endpackage

// File: rtl/poly_ctrl_seq.sv
module poly_ctrl_seq
  import poly_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output polyStrobe_t strobe,
  output logic        outValid
);

  localparam int DEPTH = PIPE_DEPTH;

  logic [DEPTH-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[DEPTH-2:0], inValid};
    end
  end

  // Each stage loads when the token of an accepted pair reaches it.
  always_comb begin
    strobe.ldSquare = inValid;
    strobe.ldCube   = validPipe[0];
    strobe.ldFifth  = validPipe[1];
    strobe.ldTerms  = validPipe[2];
    strobe.ldSum    = validPipe[3];
    strobe.ldOut    = validPipe[4];
  end

  assign outValid = validPipe[DEPTH-1];

endmodule

// File: rtl/poly_ctrl_dp.sv
module poly_ctrl_dp
  import poly_ctrl_pkg::*;
#(
  parameter int W        = 32,
  parameter int FRAC     = 16,
  parameter int GAIN_Q   = 475935,
  parameter int INV6_Q   = 10923,
  parameter int INV120_Q = 546
) (
  input  logic                clk,
  input  logic                rst,
  input  polyStrobe_t         strobe,
  input  logic signed [W-1:0] inA1,
  input  logic signed [W-1:0] inA2,
  output logic signed [W-1:0] outCtrl
);

  // Guard bits let the bracketed sum of four terms be formed exactly.
  localparam int IW    = W + 3;
  localparam int PW    = 2 * W + 3;
  localparam int CARRY = 4;

  localparam logic signed [W-1:0] GAIN_C   = W'(GAIN_Q);
  localparam logic signed [W-1:0] INV6_C   = W'(INV6_Q);
  localparam logic signed [W-1:0] INV120_C = W'(INV120_Q);
  localparam logic signed [W-1:0] POS_MAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_MAX  = {1'b1, {(W-1){1'b0}}};

  // Clamp a wide value into the signed W-bit range.
  function automatic logic signed [W-1:0] clampWord(input logic signed [PW-1:0] v);
    logic [PW-W:0] top;
    top = v[PW-1:W-1];
    if ((&top) || !(|top)) begin
      return v[W-1:0];
    end else if (v[PW-1]) begin
      return NEG_MAX;
    end else begin
      return POS_MAX;
    end
  endfunction

  // Fixed-point product: full-width multiply, arithmetic shift, clamp.
  function automatic logic signed [W-1:0] qMul(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    logic signed [PW-1:0] prod;
    ea   = PW'(a);
    eb   = PW'(b);
    prod = ea * eb;
    return clampWord(prod >>> FRAC);
  endfunction

  // Gain stage: the wide bracketed sum times the gain, shifted and clamped.
  function automatic logic signed [W-1:0] applyGain(input logic signed [IW-1:0] s);
    logic signed [PW-1:0] es;
    logic signed [PW-1:0] eg;
    logic signed [PW-1:0] prod;
    es   = PW'(s);
    eg   = PW'(GAIN_C);
    prod = es * eg;
    return clampWord(prod >>> FRAC);
  endfunction

  // Delay line that carries both states alongside the power chain.
  logic [CARRY-1:0]    carryEn;
  logic signed [W-1:0] a1Pipe [CARRY];
  logic signed [W-1:0] a2Pipe [CARRY];

  assign carryEn = {strobe.ldTerms, strobe.ldFifth, strobe.ldCube, strobe.ldSquare};

  for (genvar g = 0; g < CARRY; g++) begin : gCarry
    if (g == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (rst) begin
          a1Pipe[g] <= '0;
          a2Pipe[g] <= '0;
        end else if (carryEn[g]) begin
          a1Pipe[g] <= inA1;
          a2Pipe[g] <= inA2;
        end
      end
    end else begin : gTail
      always_ff @(posedge clk) begin
        if (rst) begin
          a1Pipe[g] <= '0;
          a2Pipe[g] <= '0;
        end else if (carryEn[g]) begin
          a1Pipe[g] <= a1Pipe[g-1];
          a2Pipe[g] <= a2Pipe[g-1];
        end
      end
    end
  end

  // Power chain: square, cube, fifth power.
  logic signed [W-1:0] sqS1;
  logic signed [W-1:0] sqS2;
  logic signed [W-1:0] cubeS2;
  logic signed [W-1:0] cubeS3;
  logic signed [W-1:0] fifthS3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sqS1 <= '0;
    end else if (strobe.ldSquare) begin
      sqS1 <= qMul(inA1, inA1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cubeS2 <= '0;
      sqS2   <= '0;
    end else if (strobe.ldCube) begin
      cubeS2 <= qMul(sqS1, a1Pipe[0]);
      sqS2   <= sqS1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifthS3 <= '0;
      cubeS3  <= '0;
    end else if (strobe.ldFifth) begin
      fifthS3 <= qMul(cubeS2, sqS2);
      cubeS3  <= cubeS2;
    end
  end

  // Coefficient scaling of the two nonlinear terms.
  logic signed [W-1:0] cubeTermS4;
  logic signed [W-1:0] fifthTermS4;

  always_ff @(posedge clk) begin
    if (rst) begin
      cubeTermS4  <= '0;
      fifthTermS4 <= '0;
    end else if (strobe.ldTerms) begin
      cubeTermS4  <= qMul(cubeS3, INV6_C);
      fifthTermS4 <= qMul(fifthS3, INV120_C);
    end
  end

  // Bracketed sum, formed exactly with guard bits.
  logic signed [IW-1:0] sumNext;
  logic signed [IW-1:0] sumS5;

  always_comb begin
    sumNext = IW'(a1Pipe[CARRY-1]) + IW'(a1Pipe[CARRY-1])
            - IW'(cubeTermS4) + IW'(fifthTermS4)
            - IW'(a2Pipe[CARRY-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumS5 <= '0;
    end else if (strobe.ldSum) begin
      sumS5 <= sumNext;
    end
  end

  // Output register: gain, shift, saturate; holds between results.
  logic signed [W-1:0] outQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      outQ <= '0;
    end else if (strobe.ldOut) begin
      outQ <= applyGain(sumS5);
    end
  end

  assign outCtrl = outQ;

endmodule

// File: rtl/poly_ctrl_law.sv
module poly_ctrl_law
  import poly_ctrl_pkg::*;
#(
  parameter int W        = 32,
  parameter int FRAC     = 16,
  parameter int GAIN_Q   = 475935,
  parameter int INV6_Q   = 10923,
  parameter int INV120_Q = 546
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic signed [W-1:0] inA1,
  input  logic signed [W-1:0] inA2,
  output logic                outValid,
  output logic signed [W-1:0] outCtrl
);

  polyStrobe_t strobe;

  poly_ctrl_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  poly_ctrl_dp #(
    .W        (W),
    .FRAC     (FRAC),
    .GAIN_Q   (GAIN_Q),
    .INV6_Q   (INV6_Q),
    .INV120_Q (INV120_Q)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inA1    (inA1),
    .inA2    (inA2),
    .outCtrl (outCtrl)
  );

endmodule

// File: rtl/poly_ctrl_law_chk.sv
module poly_ctrl_law_chk #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic signed [W-1:0] inA1,
  input logic signed [W-1:0] inA2,
  input logic                outValid,
  input logic signed [W-1:0] outCtrl
);

  // Edges since reset release, saturating at 15.
  logic [3:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
    end else if (sinceRst != 4'd15) begin
      sinceRst <= sinceRst + 4'd1;
    end
  end

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outCtrl == '0));

  // R5: every accepted pair is answered six edges later
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##6 outValid);

  // R5: no result strobe without an accepted pair six edges before
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceRst >= 4'd6 && $past(inValid, 6)));

  // R7: output holds while no result is announced
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!outValid && sinceRst != 4'd0) |-> $stable(outCtrl));

  // R8: zero operands give a zero result
  assert_zero_in_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && inA1 == '0 && inA2 == '0) |-> ##6 (outCtrl == '0));

endmodule

bind poly_ctrl_law poly_ctrl_law_chk #(.W(W)) u_chk (.*);

// File: tb/poly_ctrl_law_bench.sv
module poly_ctrl_law_bench;

  localparam int W   = 32;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic signed [W-1:0] inA1 = '0;
  logic signed [W-1:0] inA2 = '0;
  logic        outValid;
  logic signed [W-1:0] outCtrl;

  poly_ctrl_law u_poly_ctrl_law (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inA1     (inA1),
    .inA2     (inA2),
    .outValid (outValid),
    .outCtrl  (outCtrl)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  int    expQ[$];
  int    dueQ[$];
  string tagQ[$];

  // Reference model built from R2, R3 and R4.
  function automatic longint clamp32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint qm(input longint a, input longint b);
    return clamp32((a * b) >>> 16);
  endfunction

  function automatic int refLaw(input int a1, input int a2);
    longint x, y, sq, cu, fi, t3, t5, s;
    x  = a1;
    y  = a2;
    sq = qm(x, x);
    cu = qm(sq, x);
    fi = qm(cu, sq);
    t3 = qm(cu, 64'sd10923);
    t5 = qm(fi, 64'sd546);
    s  = 2 * x - t3 + t5 - y;
    return int'(clamp32((s * 64'sd475935) >>> 16));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: presents one pair and records the expected item.
  task automatic send(input int a1, input int a2, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inA1    = a1;
    inA2    = a2;
    expQ.push_back(refLaw(a1, a2));
    dueQ.push_back(cyc + LAT);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: pops and compares each announced result.
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected strobe", 1, 0);
      end else begin
        int    e;
        int    d;
        string t;
        e = expQ.pop_front();
        d = dueQ.pop_front();
        t = tagQ.pop_front();
        check(cyc == d, "R5", {t, " latency"}, cyc, d);
        check(outCtrl == e, t, "value", outCtrl, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (5) @(negedge clk);
    // R1: outputs cleared under reset
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(outCtrl == 0, "R1", "outCtrl in reset", outCtrl, 0);
    rst = 1'b0;
    idle(2);

    // R8: zero pair
    send(0, 0, "R8 zero");
    idle(8);
    // R2: x = 1.0, y = 0
    send(32'h0001_0000, 0, "R2 one");
    idle(8);
    // R2: x = -1.0
    send(-32'sh0001_0000, 0, "R2 minus one");
    idle(8);
    // R2/R3: x = 0.5, y = 0.25
    send(32'h0000_8000, 32'h0000_4000, "R3 half");
    idle(8);
    // R2: only y, y = -2.0
    send(0, -32'sh0002_0000, "R2 y only");
    idle(8);
    // R3: clamped powers, x = 100.0 drives negative saturation (R4)
    send(32'd100 <<< 16, 0, "R4 negative sat");
    idle(8);
    // R4: y at most negative code drives positive saturation
    send(0, 32'h8000_0000, "R4 positive sat");
    idle(8);
    // R3: fractional step value with floor rounding
    send(-32'sd3, 32'sd7, "R3 tiny");
    idle(8);

    // R6: back-to-back burst
    for (int i = 0; i < 10; i++) begin
      send((i - 5) * 32'sd23456, i * 32'sd9876 - 32'sd30000, "R6 burst");
    end
    idle(12);

    // R7: ignored operands, output held
    held = outCtrl;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inA1    = 32'sd12345 * (i + 1);
      inA2    = -32'sd777 * (i + 3);
      check(outValid == 1'b0, "R7", "strobe while idle", outValid, 0);
      check(outCtrl == held, "R7", "held value", outCtrl, held);
    end
    check(expQ.size() == 0, "R6", "results outstanding", expQ.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule